// File: doc/BRIEF.md
# Multiplierless 16-Point Streaming FFT

This block computes a 16-point radix-2 decimation-in-time FFT on signed 16-bit complex samples. Samples arrive one per clock in natural time order, qualified by `in_valid`, with `in_last` flagging the sixteenth sample of a frame. Results leave one per clock in natural frequency order, qualified by `out_valid`, with `out_last` flagging bin 15. A new frame may begin on the clock right after the previous frame's last sample, so the block can run at full rate with no gaps.

The datapath holds no multiplier. The twiddles of the two 2-point and 4-point stages are exact (pass, or swap-and-negate for -j). In the 8-point and 16-point stages every twiddle, including the trivial ones, is built from constant shift-and-add networks scaled by 2^14, and the lane that is not rotated is shifted by the same amount. Because every rotator of a stage shares one nominal gain, the gain of the whole transform is a single power of two. One arithmetic right shift by 32 (four butterfly doublings plus two rotator scalings) removes it. That shift leaves the output at DFT/16, rounded half up and saturated to 16 bits.

Top module: `fft16_stream`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `out_last` stay low until a complete frame has been accepted.
- R2: Each frame produces exactly 16 consecutive output cycles with `out_valid` high, carrying bins 0 to 15 in natural order; `out_last` is high only on bin 15.
- R3: Each output bin equals round-half-up(X[k]/16) within ±2 LSB on both real and imaginary parts, where X[k] = Σ x[n]·e^(-j2πkn/16); this holds for impulses, single complex tones and random frames.
- R4: An output component whose scaled value exceeds the 16-bit range is clamped to 32767 or -32768.
- R5: Bin 0 of a frame is presented on the second rising edge after the edge that accepts the frame's last sample.
- R6: Cycles with `in_valid` low are ignored, whatever `in_last` and the data carry; the frame is formed from the valid samples only.
- R7: A frame that starts on the clock after the previous `in_last` is accepted; the two result bursts follow each other with no gap and neither is corrupted.
- R8: A constant (DC) input frame gives bin 0 exactly equal to the input value and every other bin exactly zero.
- R9: An impulse at sample 0 gives every bin exactly equal to round(x[0]/16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_last | input | 1 | Marks the sixteenth sample of a frame (valid only with `in_valid`) |
| in_re | input | 16 | Input sample, real part, two's complement |
| in_im | input | 16 | Input sample, imaginary part, two's complement |
| out_valid | output | 1 | Output bin qualifier |
| out_last | output | 1 | High on bin 15 |
| out_re | output | 16 | Output bin, real part, two's complement |
| out_im | output | 16 | Output bin, imaginary part, two's complement |

## Verification
The bench drives impulses at the first and a later sample, DC, complex tones at low, middle and high bins, and random full-scale frames, and compares every bin against a real-valued DFT worked out in the bench. A wrong bit-reversal or swapped twiddle would scatter energy into the wrong bins, and a lane left unscaled would show a bin-0 or impulse result off by a power of two. DC and sample-0 impulses are checked for exact values, which catches any rounding bias or stray rotation on the unrotated path. A square-wave frame pushes bin 1 beyond full scale to catch a result that wraps instead of clamping. Frames with an idle cycle carrying a false `in_last`, and back-to-back frames, catch a write counter that advances or restarts on invalid cycles and an output bank that is reloaded while the previous burst is still draining.

// File: rtl/fft16_pkg.sv
`timescale 1ns/1ps
package fft16_pkg;
  localparam int DATA_W    = 16;
  localparam int NPTS      = 16;
  localparam int LOG_N     = 4;
  localparam int ROT_M     = 14;                         // rotator scale 2^ROT_M
  localparam int ROT_STG   = 2;                          // first stage index with scaled rotators
  localparam int ACC_W     = DATA_W + LOG_N + 2*(ROT_M+1) + 2;
  localparam int OUT_SHIFT = LOG_N + (LOG_N-ROT_STG)*ROT_M;

  // quarter-wave magnitudes, rounded, for 2^ROT_M scale
  localparam int TW_Q0 = 1 << ROT_M;  // cos 0
  localparam int TW_Q1 = 15137;       // cos 22.5 deg
  localparam int TW_Q2 = 11585;       // cos 45 deg
  localparam int TW_Q3 = 6270;        // cos 67.5 deg

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef struct packed { acc_t re; acc_t im; } cpx_t;

  // scaled cosine of 2*pi*k/NPTS, k in 0..7
  function automatic int tw_cos(input int k);
    case (k)
      0: return TW_Q0;   1: return TW_Q1;   2: return TW_Q2;   3: return TW_Q3;
      4: return 0;       5: return -TW_Q3;  6: return -TW_Q2;  default: return -TW_Q1;
    endcase
  endfunction

  // scaled sine of 2*pi*k/NPTS, k in 0..7
  function automatic int tw_sin(input int k);
    case (k)
      0: return 0;       1: return TW_Q3;   2: return TW_Q2;   3: return TW_Q1;
      4: return TW_Q0;   5: return TW_Q1;   6: return TW_Q2;   default: return TW_Q3;
    endcase
  endfunction

  // product with a constant, as a sum of shifted copies
  function automatic acc_t kmul(input acc_t x, input int c);
    acc_t acc;
    int   mag;
    acc = '0;
    mag = (c < 0) ? -c : c;
    for (int b = 0; b <= ROT_M; b++)
      if (mag[b]) acc = acc + (x <<< b);
    return (c < 0) ? -acc : acc;
  endfunction

  function automatic logic [LOG_N-1:0] bitrev(input logic [LOG_N-1:0] a);
    logic [LOG_N-1:0] r;
    for (int i = 0; i < LOG_N; i++) r[i] = a[LOG_N-1-i];
    return r;
  endfunction

  // remove 2^OUT_SHIFT, round half up, clamp to DATA_W
  function automatic logic signed [DATA_W-1:0] round_sat(input acc_t v);
    acc_t r;
    r = (v + (acc_t'(1) <<< (OUT_SHIFT-1))) >>> OUT_SHIFT;
    if (r > acc_t'((1 << (DATA_W-1)) - 1)) return {1'b0, {(DATA_W-1){1'b1}}};
    if (r < -acc_t'(1 << (DATA_W-1)))      return {1'b1, {(DATA_W-1){1'b0}}};
    return r[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/fft16_bfly.sv
`timescale 1ns/1ps
module fft16_bfly
  import fft16_pkg::*;
#(
  parameter int TW_K   = 0,   // twiddle exponent in units of 2*pi/NPTS
  parameter bit SCALED = 1'b0 // 1: constant shift-add rotator at 2^ROT_M
)(
  input  cpx_t a,
  input  cpx_t b,
  output cpx_t x,
  output cpx_t y
);
  cpx_t a_s, w_b;

  generate
    if (SCALED) begin : g_rot
      always_comb begin
        a_s.re = a.re <<< ROT_M;
        a_s.im = a.im <<< ROT_M;
        w_b.re = kmul(b.re, tw_cos(TW_K)) + kmul(b.im, tw_sin(TW_K));
        w_b.im = kmul(b.im, tw_cos(TW_K)) - kmul(b.re, tw_sin(TW_K));
      end
    end else if (TW_K == NPTS/4) begin : g_negj
      always_comb begin
        a_s    = a;
        w_b.re = b.im;
        w_b.im = -b.re;
      end
    end else begin : g_pass
      always_comb begin
        a_s = a;
        w_b = b;
      end
    end
  endgenerate

  always_comb begin
    x.re = a_s.re + w_b.re;
    x.im = a_s.im + w_b.im;
    y.re = a_s.re - w_b.re;
    y.im = a_s.im - w_b.im;
  end
endmodule

// File: rtl/fft16_core.sv
`timescale 1ns/1ps
module fft16_core
  import fft16_pkg::*;
(
  input  cpx_t din  [NPTS],
  output cpx_t dout [NPTS]
);
  cpx_t st [LOG_N+1][NPTS];

  for (genvar i = 0; i < NPTS; i++) begin : g_io
    assign st[0][i] = din[i];
    assign dout[i]  = st[LOG_N][i];
  end

  for (genvar s = 0; s < LOG_N; s++) begin : g_stage
    for (genvar bi = 0; bi < NPTS/2; bi++) begin : g_bf
      localparam int H   = 1 << s;
      localparam int J   = bi % H;
      localparam int TOP = (bi / H) * 2 * H + J;
      localparam int BOT = TOP + H;
      localparam int K   = J * (NPTS / (2*H));
      fft16_bfly #(.TW_K(K), .SCALED(s >= ROT_STG)) u_bf (
        .a (st[s][TOP]),
        .b (st[s][BOT]),
        .x (st[s+1][TOP]),
        .y (st[s+1][BOT])
      );
    end
  end
endmodule

// File: rtl/fft16_stream.sv
`timescale 1ns/1ps
module fft16_stream
  import fft16_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic                     out_last,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);
  logic signed [DATA_W-1:0] buf_re [NPTS];
  logic signed [DATA_W-1:0] buf_im [NPTS];
  logic signed [DATA_W-1:0] bank_re [NPTS];
  logic signed [DATA_W-1:0] bank_im [NPTS];
  logic [LOG_N-1:0] wr_cnt, rd_cnt;
  logic frame_go, out_active;
  cpx_t core_in [NPTS];
  cpx_t core_out [NPTS];

  // named internal events
  logic sample_take, frame_close, bank_load, burst_end;
  assign sample_take = in_valid;
  assign frame_close = in_valid & in_last;
  assign bank_load   = frame_go;
  assign burst_end   = out_active && (rd_cnt == LOG_N'(NPTS-1));

  // input frame, stored in bit-reversed position
  always_ff @(posedge clk)
    if (sample_take) begin
      buf_re[bitrev(wr_cnt)] <= in_re;
      buf_im[bitrev(wr_cnt)] <= in_im;
    end

  always_comb
    for (int i = 0; i < NPTS; i++) begin
      core_in[i].re = acc_t'(buf_re[i]);
      core_in[i].im = acc_t'(buf_im[i]);
    end

  fft16_core u_core (.din(core_in), .dout(core_out));

  always_ff @(posedge clk)
    if (bank_load)
      for (int i = 0; i < NPTS; i++) begin
        bank_re[i] <= round_sat(core_out[i].re);
        bank_im[i] <= round_sat(core_out[i].im);
      end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt     <= '0;
      frame_go   <= 1'b0;
      out_active <= 1'b0;
      rd_cnt     <= '0;
    end else begin
      frame_go <= frame_close;
      if (frame_close)      wr_cnt <= '0;
      else if (sample_take) wr_cnt <= wr_cnt + 1'b1;
      if (bank_load) begin
        out_active <= 1'b1;
        rd_cnt     <= '0;
      end else if (burst_end) begin
        out_active <= 1'b0;
        rd_cnt     <= '0;
      end else if (out_active) begin
        rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  assign out_valid = out_active;
  assign out_last  = burst_end;
  assign out_re    = bank_re[rd_cnt];
  assign out_im    = bank_im[rd_cnt];

  // a burst starts only two edges after a frame closes
  p_burst_after_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_close, 2));
  // a new bank never cuts short a burst still draining
  p_load_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |-> (!out_active || burst_end));
  // bins advance one per clock inside a burst
  p_bins_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_active && !burst_end && !bank_load) |=> (out_valid && rd_cnt == LOG_N'($past(rd_cnt) + 1'b1)));
  // a finished burst drops valid unless a new one loads
  p_burst_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !bank_load) |=> !out_valid);
  // frame end restarts the write index
  p_wr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_close |=> (wr_cnt == '0));
  // idle input cycles leave the write index alone
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_cnt));
endmodule

// File: tb/tb_fft16_stream.sv
`timescale 1ns/1ps
module tb_fft16_stream;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_last;
  logic signed [15:0] in_re, in_im;
  logic out_valid, out_last;
  logic signed [15:0] out_re, out_im;

  always #5 clk = ~clk;

  fft16_stream dut (.*);

  int n_chk = 0, n_fail = 0;
  int fx_r [2][16], fx_i [2][16];
  int ex_r [2][16], ex_i [2][16];
  int got_r [32], got_i [32];

  // kind, parameter, amplitude, requirement (3/8/9)
  // kinds: 0 impulse at param, 1 DC, 2 tone at bin param, 3 random with seed param
  localparam int VEC [8][4] = '{
    '{0, 0, 12000, 9}, '{0, 5, -9000, 3}, '{1, 0, 7000, 8},  '{2, 1, 20000, 3},
    '{2, 6, 15000, 3}, '{2, 13, 30000, 3}, '{3, 77, 0, 3},   '{3, 1234, 0, 3}};

  function automatic string rtag(input int r);
    case (r)
      8: return "R8"; 9: return "R9"; default: return "R3";
    endcase
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build(input int idx, input int kind, input int p, input int a);
    int s;
    real ph;
    s = p;
    for (int n = 0; n < 16; n++) begin
      ph = 2.0 * 3.14159265358979 * p * n / 16.0;
      case (kind)
        0: begin fx_r[idx][n] = (n == p) ? a : 0; fx_i[idx][n] = 0; end
        1: begin fx_r[idx][n] = a; fx_i[idx][n] = -a / 2; end
        2: begin fx_r[idx][n] = $rtoi($floor(a * $cos(ph) + 0.5));
                 fx_i[idx][n] = $rtoi($floor(a * $sin(ph) + 0.5)); end
        3: begin s = s * 1103515245 + 12345; fx_r[idx][n] = ((s >>> 8) & 32'hFFFF) - 32768;
                 s = s * 1103515245 + 12345; fx_i[idx][n] = ((s >>> 8) & 32'hFFFF) - 32768; end
        default: begin fx_r[idx][n] = (n < 8) ? 32767 : -32767;
                 fx_i[idx][n] = (n >= 4 && n < 12) ? 32767 : -32767; end
      endcase
    end
  endtask

  function automatic int qsat(input real v);
    int q;
    q = $rtoi($floor(v / 16.0 + 0.5));
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic reference(input int idx);
    for (int k = 0; k < 16; k++) begin
      real sr, si, ang;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < 16; n++) begin
        ang = 2.0 * 3.14159265358979 * k * n / 16.0;
        sr += fx_r[idx][n] * $cos(ang) + fx_i[idx][n] * $sin(ang);
        si += fx_i[idx][n] * $cos(ang) - fx_r[idx][n] * $sin(ang);
      end
      ex_r[idx][k] = qsat(sr);
      ex_i[idx][k] = qsat(si);
    end
  endtask

  task automatic send_frame(input int idx, input bit keep, input bit bubble);
    for (int n = 0; n < 16; n++) begin
      if (bubble && n == 5) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b1; in_re = 16'sh7FFF; in_im = -16'sh7000;
      end
      @(posedge clk); #1;
      in_valid = 1'b1; in_last = (n == 15);
      in_re = 16'(fx_r[idx][n]); in_im = 16'(fx_i[idx][n]);
    end
    if (!keep) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic collect(input int cnt, input bit lat, input string req);
    int waitc;
    waitc = 0;
    do begin @(negedge clk); waitc++; end while (!out_valid && waitc < 100);
    if (lat) chk(waitc == 2, "R5", "edges to first bin", waitc, 2);
    for (int i = 0; i < cnt; i++) begin
      if (i > 0) @(negedge clk);
      chk(out_valid == 1'b1, req, $sformatf("out_valid bin %0d", i), out_valid, 1);
      chk(out_last == (i % 16 == 15), "R2", $sformatf("out_last bin %0d", i), out_last, (i % 16 == 15));
      got_r[i] = out_re; got_i[i] = out_im;
    end
  endtask

  task automatic compare(input int idx, input int base, input int tol, input string req);
    for (int k = 0; k < 16; k++) begin
      chk(iabs(got_r[base+k] - ex_r[idx][k]) <= tol, req, $sformatf("re bin %0d", k), got_r[base+k], ex_r[idx][k]);
      chk(iabs(got_i[base+k] - ex_i[idx][k]) <= tol, req, $sformatf("im bin %0d", k), got_i[base+k], ex_i[idx][k]);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_re = '0; in_im = '0;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_last == 1'b0, "R1", "outputs in reset", out_valid, 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid idle after reset", out_valid, 0);
    end

    // table of vectors
    for (int v = 0; v < 8; v++) begin
      build(0, VEC[v][0], VEC[v][1], VEC[v][2]);
      reference(0);
      send_frame(0, 1'b0, 1'b0);
      collect(16, 1'b1, "R2");
      compare(0, 0, (VEC[v][3] == 3) ? 2 : 0, rtag(VEC[v][3]));
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "valid drops after bin 15", out_valid, 0);
    end

    // saturation: square-wave frame drives bin 1 imaginary past full scale
    build(0, 4, 0, 0);
    reference(0);
    send_frame(0, 1'b0, 1'b0);
    collect(16, 1'b0, "R4");
    chk(got_i[1] == -32768, "R4", "bin 1 im clamps", got_i[1], -32768);
    compare(0, 0, 2, "R4");

    // idle cycle with a false in_last inside a frame
    build(0, 3, 999, 0);
    reference(0);
    send_frame(0, 1'b0, 1'b1);
    collect(16, 1'b1, "R6");
    compare(0, 0, 2, "R6");

    // back-to-back frames
    build(0, 2, 3, 25000);
    reference(0);
    build(1, 3, 4242, 0);
    reference(1);
    fork
      begin
        send_frame(0, 1'b1, 1'b0);
        send_frame(1, 1'b0, 1'b0);
      end
      collect(32, 1'b0, "R7");
    join
    compare(0, 0, 2, "R7");
    compare(1, 16, 2, "R7");
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid drops after second burst", out_valid, 0);

    summary();
    $finish;
  end
endmodule